// File: doc/BRIEF.md
# Serial-to-Parallel Latch with Output Control

The block turns a serial bit stream into a set of per-channel drive commands. Serial data moves into a shift register one bit per rising clock edge. The bit that leaves the far end of the register appears on a cascade output, so several blocks can be chained into one longer register. A level-sensitive latch sits behind the register. While the latch is open it passes the register contents straight through. While it is closed it keeps the last value it passed.

An output-control stage decides what each channel drives. Two active-low controls, blanking and polarity, select one of four drive modes: all channels forced high, all channels forced low, each channel inverted, or each channel following its latch bit. A third active-low control releases every channel to high impedance, and it overrides the drive mode. None of these controls, nor the latch control, touches the shift register.

The block produces only the logical drive value and an enable for each channel. Level translation and the analog drivers are outside it. When the latch, blanking, polarity and high-Z controls are all held high, the block is in its default mode: latch open, normal polarity, not blanked, outputs driven. The surrounding pads are expected to pull these controls high when they are unconnected. A synchronous reset clears the register and the latch so that simulation starts from known values.

Top module: `s2p_latch_drv`

## Requirements
- R1: On each rising `clk` edge with `rst` low, the register shifts: `ser_in` enters bit 0 and bit i takes the old bit i-1. Bit i of `drive` corresponds to register bit i.
- R2: `ser_out` always equals register bit WIDTH-1. It therefore shows the `ser_in` value sampled WIDTH rising edges earlier, and it changes only on a rising edge.
- R3: A rising edge with `rst` high clears the register and the latch to all zeros. With the default controls, `drive` and `ser_out` then read zero.
- R4: While `lat_pass` is 1, the latch value equals the current register contents, with no extra cycle of delay.
- R5: While `lat_pass` is 0, the latch value keeps the contents present when it was last open, even if shifting continues.
- R6: `blank_n`=0 with `pol_n`=0 drives every bit of `drive` to 1, whatever the latch holds.
- R7: `blank_n`=0 with `pol_n`=1 drives every bit of `drive` to 0, whatever the latch holds.
- R8: `blank_n`=1 with `pol_n`=0 sets each `drive` bit to the inverse of its latch bit. `blank_n`=1 with `pol_n`=1 sets each bit equal to its latch bit.
- R9: `hiz_n`=0 forces every bit of `drive_en` to 0 (high impedance) in every mode. `hiz_n`=1 sets every bit of `drive_en` to 1.
- R10: `lat_pass`, `blank_n`, `pol_n` and `hiz_n` have no effect on shifting. The `ser_out` sequence depends only on `ser_in` and `rst`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift clock; the register moves on its rising edge |
| rst | input | 1 | Synchronous active-high clear of register and latch |
| ser_in | input | 1 | Serial data into register bit 0 |
| lat_pass | input | 1 | 1: latch transparent; 0: latch holds |
| blank_n | input | 1 | Active-low blanking; forces all channels to one level |
| pol_n | input | 1 | Active-low polarity; picks inversion or the forced level |
| hiz_n | input | 1 | Active-low high impedance for all channels |
| drive | output | WIDTH | Logical drive value per channel |
| drive_en | output | WIDTH | Per-channel enable; 0 means high impedance |
| ser_out | output | 1 | Cascade output, register bit WIDTH-1 |

## Verification
The hardest case to reach from the ports is a closed latch holding one pattern while the register behind it already carries a different one, followed by reopening the latch. The stimulus closes the latch after a known pattern has been shifted in, shifts a distinct pattern in while it stays closed, and then reopens it. The drive output must jump to the new pattern on the same cycle. A long stretch with all four controls changed at random every cycle then shows that the cascade stream never depends on them.

// File: rtl/s2p_pkg.sv
package s2p_pkg;

    // Drive mode selected by the blanking and polarity controls.
    typedef enum logic [1:0] {
        DM_ALL_HIGH = 2'd0,
        DM_ALL_LOW  = 2'd1,
        DM_INVERT   = 2'd2,
        DM_FOLLOW   = 2'd3
    } drv_mode_e;

endpackage

// File: rtl/s2p_shift.sv
module s2p_shift #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ser_in,
    output logic [WIDTH-1:0] sr_q,
    output logic [WIDTH-1:0] sr_d
);

    // Next register value: new bit enters position 0.
    always_comb begin
        sr_d = {sr_q[WIDTH-2:0], ser_in};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q <= '0;
        end else begin
            sr_q <= sr_d;
        end
    end

endmodule

// File: rtl/s2p_latch.sv
module s2p_latch #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lat_pass,
    input  logic [WIDTH-1:0] sr_q,
    input  logic [WIDTH-1:0] sr_d,
    output logic [WIDTH-1:0] hold_q,
    output logic [WIDTH-1:0] lat_q
);

    // The held copy tracks the register's next value while open,
    // so at the moment the latch closes it already matches sr_q.
    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
        end else if (lat_pass) begin
            hold_q <= sr_d;
        end
    end

    // Transparent path: open latch shows the live register.
    always_comb begin
        lat_q = lat_pass ? sr_q : hold_q;
    end

endmodule

// File: rtl/s2p_mode_dec.sv
module s2p_mode_dec
    import s2p_pkg::*;
(
    input  logic      blank_n,
    input  logic      pol_n,
    output drv_mode_e mode
);

    always_comb begin
        unique case ({blank_n, pol_n})
            2'b00:   mode = DM_ALL_HIGH;
            2'b01:   mode = DM_ALL_LOW;
            2'b10:   mode = DM_INVERT;
            default: mode = DM_FOLLOW;
        endcase
    end

endmodule

// File: rtl/s2p_out_ctl.sv
module s2p_out_ctl
    import s2p_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  drv_mode_e        mode,
    input  logic             hiz_n,
    input  logic [WIDTH-1:0] lat_q,
    output logic [WIDTH-1:0] drive,
    output logic [WIDTH-1:0] drive_en
);

    for (genvar g = 0; g < WIDTH; g++) begin : g_chan
        always_comb begin
            unique case (mode)
                DM_ALL_HIGH: drive[g] = 1'b1;
                DM_ALL_LOW:  drive[g] = 1'b0;
                DM_INVERT:   drive[g] = ~lat_q[g];
                DM_FOLLOW:   drive[g] = lat_q[g];
                default:     drive[g] = lat_q[g];
            endcase
        end
        // High impedance overrides every drive mode.
        assign drive_en[g] = hiz_n;
    end

endmodule

// File: rtl/s2p_latch_drv.sv
module s2p_latch_drv
    import s2p_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ser_in,
    input  logic             lat_pass,
    input  logic             blank_n,
    input  logic             pol_n,
    input  logic             hiz_n,
    output logic [WIDTH-1:0] drive,
    output logic [WIDTH-1:0] drive_en,
    output logic             ser_out
);

    logic [WIDTH-1:0] sr_q;
    logic [WIDTH-1:0] sr_d;
    logic [WIDTH-1:0] hold_q;
    logic [WIDTH-1:0] lat_q;
    drv_mode_e        mode;

    s2p_shift #(.WIDTH(WIDTH)) i_shift (
        .clk    (clk),
        .rst    (rst),
        .ser_in (ser_in),
        .sr_q   (sr_q),
        .sr_d   (sr_d)
    );

    s2p_latch #(.WIDTH(WIDTH)) i_latch (
        .clk      (clk),
        .rst      (rst),
        .lat_pass (lat_pass),
        .sr_q     (sr_q),
        .sr_d     (sr_d),
        .hold_q   (hold_q),
        .lat_q    (lat_q)
    );

    s2p_mode_dec i_mode (
        .blank_n (blank_n),
        .pol_n   (pol_n),
        .mode    (mode)
    );

    s2p_out_ctl #(.WIDTH(WIDTH)) i_out (
        .mode     (mode),
        .hiz_n    (hiz_n),
        .lat_q    (lat_q),
        .drive    (drive),
        .drive_en (drive_en)
    );

    assign ser_out = sr_q[WIDTH-1];

endmodule

// File: rtl/s2p_latch_drv_chk.sv
module s2p_latch_drv_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             ser_in,
    input logic             lat_pass,
    input logic             blank_n,
    input logic             pol_n,
    input logic             hiz_n,
    input logic [WIDTH-1:0] drive,
    input logic [WIDTH-1:0] drive_en,
    input logic             ser_out,
    input logic [WIDTH-1:0] sr_q,
    input logic [WIDTH-1:0] hold_q,
    input logic [WIDTH-1:0] lat_q
);

    p_shift_in_r1: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> sr_q[0] == $past(ser_in));

    p_cascade_r2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ser_out == $past(sr_q[WIDTH-2]));

    p_cleared_r3: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (sr_q == '0) && (hold_q == '0));

    p_open_r4: assert property (@(posedge clk) disable iff (rst)
        lat_pass |-> lat_q == sr_q);

    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(lat_pass)) |-> $stable(hold_q));

    p_all_high_r6: assert property (@(posedge clk) disable iff (rst)
        (!blank_n && !pol_n) |-> drive == {WIDTH{1'b1}});

    p_all_low_r7: assert property (@(posedge clk) disable iff (rst)
        (!blank_n && pol_n) |-> drive == '0);

    p_invert_r8: assert property (@(posedge clk) disable iff (rst)
        (blank_n && !pol_n) |-> drive == ~lat_q);

    p_hiz_r9: assert property (@(posedge clk) disable iff (rst)
        !hiz_n |-> drive_en == '0);

endmodule

bind s2p_latch_drv s2p_latch_drv_chk #(.WIDTH(WIDTH)) i_chk (
    .clk      (clk),
    .rst      (rst),
    .ser_in   (ser_in),
    .lat_pass (lat_pass),
    .blank_n  (blank_n),
    .pol_n    (pol_n),
    .hiz_n    (hiz_n),
    .drive    (drive),
    .drive_en (drive_en),
    .ser_out  (ser_out),
    .sr_q     (sr_q),
    .hold_q   (hold_q),
    .lat_q    (lat_q)
);

// File: tb/test_s2p_latch_drv.sv
module test_s2p_latch_drv;

    localparam int W     = 8;
    localparam int CLK_T = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         ser_in = 1'b0;
    logic         lat_pass = 1'b1;
    logic         blank_n = 1'b1;
    logic         pol_n = 1'b1;
    logic         hiz_n = 1'b1;
    logic [W-1:0] drive;
    logic [W-1:0] drive_en;
    logic         ser_out;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    always #(CLK_T/2) clk = ~clk;

    s2p_latch_drv #(.WIDTH(W)) i_s2p_latch_drv (
        .clk      (clk),
        .rst      (rst),
        .ser_in   (ser_in),
        .lat_pass (lat_pass),
        .blank_n  (blank_n),
        .pol_n    (pol_n),
        .hiz_n    (hiz_n),
        .drive    (drive),
        .drive_en (drive_en),
        .ser_out  (ser_out)
    );

    // Reference model: history of serial bits, newest first.
    bit           hist[$];
    logic [W-1:0] m_hold = '0;
    bit           m_was_rst = 1'b1;

    function automatic logic [W-1:0] pack_hist();
        logic [W-1:0] v;
        for (int i = 0; i < W; i++) v[i] = hist[i];
        return v;
    endfunction

    initial begin
        for (int i = 0; i < W; i++) hist.push_back(1'b0);
    end

    always @(posedge clk) begin
        m_was_rst <= rst;
        if (rst) begin
            for (int i = 0; i < W; i++) hist[i] = 1'b0;
            m_hold = '0;
        end else begin
            hist.push_front(ser_in);
            void'(hist.pop_back());
            if (lat_pass) m_hold = pack_hist();
        end
    end

    task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare();
        logic [W-1:0] lat;
        logic [W-1:0] exp_drv;
        string        dtag;
        lat = lat_pass ? pack_hist() : m_hold;
        if (!blank_n && !pol_n)      begin exp_drv = '1;   dtag = "R6"; end
        else if (!blank_n)           begin exp_drv = '0;   dtag = "R7"; end
        else if (!pol_n)             begin exp_drv = ~lat; dtag = "R8"; end
        else if (lat_pass)           begin exp_drv = lat;  dtag = "R1/R4"; end
        else                         begin exp_drv = lat;  dtag = "R5"; end
        if (m_was_rst) dtag = {dtag, " R3"};
        check(dtag, drive, exp_drv);
        check("R9", drive_en, hiz_n ? '1 : '0);
        if (lat_pass && blank_n && pol_n && hiz_n)
            check(m_was_rst ? "R2 R3" : "R2", {{(W-1){1'b0}}, ser_out},
                  {{(W-1){1'b0}}, hist[W-1]});
        else
            check("R10", {{(W-1){1'b0}}, ser_out}, {{(W-1){1'b0}}, hist[W-1]});
    endtask

    // One cycle: check current outputs, then apply new inputs.
    task automatic step(logic r, logic d, logic lp, logic bn, logic pn, logic hn);
        @(negedge clk);
        compare();
        rst = r; ser_in = d; lat_pass = lp; blank_n = bn; pol_n = pn; hiz_n = hn;
    endtask

    task automatic shift_byte(logic [W-1:0] v, logic lp, logic bn, logic pn, logic hn);
        for (int i = W - 1; i >= 0; i--) step(1'b0, v[i], lp, bn, pn, hn);
    endtask

    initial begin
        // R3: reset state
        repeat (3) step(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
        // R1, R2, R4: normal transparent shifting
        shift_byte(8'hA5, 1'b1, 1'b1, 1'b1, 1'b1);
        shift_byte(8'h3C, 1'b1, 1'b1, 1'b1, 1'b1);
        // R5: close latch, shift a different pattern, then reopen
        shift_byte(8'hF0, 1'b0, 1'b1, 1'b1, 1'b1);
        shift_byte(8'h96, 1'b0, 1'b1, 1'b1, 1'b1);
        step(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
        step(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
        // R6, R7, R8: drive modes
        shift_byte(8'h5A, 1'b1, 1'b0, 1'b0, 1'b1);
        shift_byte(8'hC3, 1'b1, 1'b0, 1'b1, 1'b1);
        shift_byte(8'h81, 1'b1, 1'b1, 1'b0, 1'b1);
        shift_byte(8'h7E, 1'b0, 1'b1, 1'b0, 1'b1);
        // R9: high impedance across modes
        shift_byte(8'h0F, 1'b1, 1'b0, 1'b0, 1'b0);
        shift_byte(8'hE7, 1'b1, 1'b1, 1'b0, 1'b0);
        shift_byte(8'h24, 1'b0, 1'b1, 1'b1, 1'b0);
        // R3: reset in the middle of a run
        shift_byte(8'hFF, 1'b1, 1'b1, 1'b1, 1'b1);
        step(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
        step(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
        shift_byte(8'h69, 1'b1, 1'b1, 1'b1, 1'b1);
        // R10: controls changed at random every cycle
        for (int i = 0; i < 400; i++) begin
            logic [4:0] rv;
            rv = 5'($urandom());
            step(1'b0, rv[0], rv[1], rv[2], rv[3], rv[4]);
        end
        step(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
        step(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_T * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog (all requirements): actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule